// File: doc/BRIEF.md
# Interrupt and Reset Control Register

This block is a single memory-mapped control word. It holds the interrupt priority-grouping field and lets a debugger or privileged software ask for three actions. The first is a system-wide reset request. The second is a local core reset. The third clears all active exception state. The word also reports the memory-system byte order, which comes from a strap pin.

A write changes nothing unless its upper half carries the write key 0x05FA. On a read, the upper half returns 0xFA05, which is the write key with its two bytes swapped.

The system reset request is a level. It stays raised until the block is reset or until a local-reset action is issued. The local-reset and clear-active actions are one-cycle pulses. They are issued only while the core reports that it is halted in debug state. If one keyed write asks for both a local reset and a system reset, the system request takes priority.

Top module: `intrst_ctl`

## Requirements
- R1: A write whose bits [31:16] differ from 0x05FA is discarded. It changes neither the priority field nor the system request, and it raises no pulse.
- R2: A read always returns 0xFA05 in bits [31:16].
- R3: Read bit 15 follows the endianness strap (0 = little, 1 = big). A write never changes it.
- R4: The priority-group field is read and written at bits [10:8], is driven on `prio_group`, and is 0 after reset.
- R5: A keyed write with bit 2 = 1 raises `sys_rst_req` from the cycle after the write. Bit 2 reads back its level. A keyed write with bit 2 = 0 does not lower it.
- R6: While `core_halted` is 1, a keyed write with bit 0 = 1 and bit 2 = 0 drives `core_rst_pulse` high for exactly the following cycle and clears `sys_rst_req`.
- R7: While `core_halted` is 1, a keyed write with bit 1 = 1 drives `clr_active_pulse` high for exactly the following cycle.
- R8: A keyed write made while `core_halted` is 0 raises neither pulse. The priority field is still updated.
- R9: A keyed write with both bit 0 and bit 2 set raises only `sys_rst_req`. No local-reset pulse follows.
- R10: Bits 1 and 0 read as 0, and so do bits [14:11] and [7:3].
- R11: After reset, all three outputs are 0 and the priority field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Access strobe for this word |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read image of the word |
| endian_strap | input | 1 | Byte-order strap, 1 = big endian |
| core_halted | input | 1 | Core is halted in debug state |
| prio_group | output | 3 | Priority-grouping field |
| sys_rst_req | output | 1 | System reset request level |
| core_rst_pulse | output | 1 | One-cycle local core reset pulse |
| clr_active_pulse | output | 1 | One-cycle clear-active-exceptions pulse |

## Verification
Every piece of held state in this block appears on a port. A wrong priority value or a wrong request level therefore shows on `prio_group`, `sys_rst_req` and the read image in the cycle right after the write that caused it. A wrongly gated or stretched pulse shows one cycle after the write, or stays high one cycle later than it should. The bench checks both of those cycles on every write. It also reaches the sticky request through several sequences of set, keep, clear and set again.

// File: rtl/irc_pkg.sv
package irc_pkg;
  // Action-bit positions decoded from the low write bits
  localparam int unsigned LRST_BIT = 0;
  localparam int unsigned CLRA_BIT = 1;
  localparam int unsigned SREQ_BIT = 2;
  localparam int unsigned END_BIT  = 15;

  typedef struct packed {
    logic sreq_set;
    logic lrst;
    logic clra;
  } irc_req_t;
endpackage

// File: rtl/irc_keychk.sv
module irc_keychk #(
  parameter int unsigned KEY_W  = 16,
  parameter logic [KEY_W-1:0] WR_KEY = 16'h05FA
) (
  input  logic             sel,
  input  logic             wr,
  input  logic [KEY_W-1:0] key_in,
  output logic             accept
);
  always_comb begin
    accept = sel && wr && (key_in == WR_KEY);
  end
endmodule

// File: rtl/irc_cmd.sv
module irc_cmd
  import irc_pkg::*;
(
  input  logic       accept,
  input  logic       halted,
  input  logic [2:0] act_bits,
  output irc_req_t   req
);
  always_comb begin
    req.sreq_set = accept && act_bits[SREQ_BIT];
    // System request wins over a local reset in the same write
    req.lrst     = accept && halted && act_bits[LRST_BIT] && !act_bits[SREQ_BIT];
    req.clra     = accept && halted && act_bits[CLRA_BIT];
  end
endmodule

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int unsigned PG_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  irc_req_t        req,
  input  logic [PG_W-1:0] pg_wdata,
  output logic [PG_W-1:0] pg_q,
  output logic            sreq_q,
  output logic            lrst_q,
  output logic            clra_q
);
  logic [PG_W-1:0] pg_d;
  logic            sreq_d;
  logic            lrst_d;
  logic            clra_d;

  always_comb begin
    pg_d   = pg_q;
    sreq_d = sreq_q;
    if (accept) begin
      pg_d = pg_wdata;
    end
    if (req.sreq_set) begin
      sreq_d = 1'b1;
    end else if (req.lrst) begin
      sreq_d = 1'b0;
    end
    lrst_d = req.lrst;
    clra_d = req.clra;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q   <= '0;
      sreq_q <= 1'b0;
      lrst_q <= 1'b0;
      clra_q <= 1'b0;
    end else begin
      pg_q   <= pg_d;
      sreq_q <= sreq_d;
      lrst_q <= lrst_d;
      clra_q <= clra_d;
    end
  end
endmodule

// File: rtl/irc_rdmux.sv
module irc_rdmux
  import irc_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned PG_W   = 3,
  parameter int unsigned PG_LSB = 8,
  parameter logic [KEY_W-1:0] RD_KEY = 16'hFA05
) (
  input  logic [PG_W-1:0] pg,
  input  logic            sreq,
  input  logic            strap,
  output logic [DW-1:0]   rdata
);
  localparam int unsigned KEY_LSB = DW - KEY_W;

  always_comb begin
    rdata                   = '0;
    rdata[DW-1:KEY_LSB]     = RD_KEY;
    rdata[END_BIT]          = strap;
    rdata[PG_LSB +: PG_W]   = pg;
    rdata[SREQ_BIT]         = sreq;
  end
endmodule

// File: rtl/intrst_ctl.sv
module intrst_ctl
  import irc_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned PG_W   = 3,
  parameter int unsigned PG_LSB = 8,
  parameter logic [KEY_W-1:0] WR_KEY = 16'h05FA,
  parameter logic [KEY_W-1:0] RD_KEY = 16'hFA05
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            endian_strap,
  input  logic            core_halted,
  output logic [PG_W-1:0] prio_group,
  output logic            sys_rst_req,
  output logic            core_rst_pulse,
  output logic            clr_active_pulse
);
  localparam int unsigned KEY_LSB = DW - KEY_W;

  logic     accept;
  irc_req_t req;
  logic     unused_wbits;

  assign unused_wbits = ^{bus_wdata[KEY_LSB-1:PG_LSB+PG_W], bus_wdata[PG_LSB-1:SREQ_BIT+1]};

  irc_keychk #(.KEY_W(KEY_W), .WR_KEY(WR_KEY)) u_key (
    .sel    (bus_sel),
    .wr     (bus_wr),
    .key_in (bus_wdata[DW-1:KEY_LSB]),
    .accept (accept)
  );

  irc_cmd u_cmd (
    .accept   (accept),
    .halted   (core_halted),
    .act_bits (bus_wdata[2:0]),
    .req      (req)
  );

  irc_regs #(.PG_W(PG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req      (req),
    .pg_wdata (bus_wdata[PG_LSB +: PG_W]),
    .pg_q     (prio_group),
    .sreq_q   (sys_rst_req),
    .lrst_q   (core_rst_pulse),
    .clra_q   (clr_active_pulse)
  );

  irc_rdmux #(
    .DW(DW), .KEY_W(KEY_W), .PG_W(PG_W), .PG_LSB(PG_LSB), .RD_KEY(RD_KEY)
  ) u_rd (
    .pg    (prio_group),
    .sreq  (sys_rst_req),
    .strap (endian_strap),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/intrst_ctl_chk.sv
module intrst_ctl_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned PG_W  = 3,
  parameter logic [KEY_W-1:0] WR_KEY = 16'h05FA
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic            core_halted,
  input logic [PG_W-1:0] prio_group,
  input logic            sys_rst_req,
  input logic            core_rst_pulse,
  input logic            clr_active_pulse
);
  logic keyed;
  logic badkey;
  assign keyed  = bus_sel && bus_wr && (bus_wdata[DW-1:DW-KEY_W] == WR_KEY);
  assign badkey = bus_sel && bus_wr && (bus_wdata[DW-1:DW-KEY_W] != WR_KEY);

  AST_BADKEY_KEEPS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    badkey |=> $stable(prio_group)); // R1

  AST_SREQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> (sys_rst_req || core_rst_pulse)); // R5

  AST_LRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_pulse |-> $past(keyed && core_halted && bus_wdata[0])); // R6

  AST_CLRA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active_pulse |-> $past(keyed && core_halted && bus_wdata[1])); // R7

  AST_RUNNING_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !core_halted) |=> (!core_rst_pulse && !clr_active_pulse)); // R8

  AST_BOTH_SREQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (keyed && bus_wdata[0] && bus_wdata[2]) |=> (sys_rst_req && !core_rst_pulse)); // R9
endmodule

bind intrst_ctl intrst_ctl_chk #(
  .DW(DW), .KEY_W(KEY_W), .PG_W(PG_W), .WR_KEY(WR_KEY)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_sel          (bus_sel),
  .bus_wr           (bus_wr),
  .bus_wdata        (bus_wdata),
  .core_halted      (core_halted),
  .prio_group       (prio_group),
  .sys_rst_req      (sys_rst_req),
  .core_rst_pulse   (core_rst_pulse),
  .clr_active_pulse (clr_active_pulse)
);

// File: tb/intrst_ctl_bench.sv
module intrst_ctl_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        endian_strap;
  logic        core_halted;
  logic [2:0]  prio_group;
  logic        sys_rst_req;
  logic        core_rst_pulse;
  logic        clr_active_pulse;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  intrst_ctl u_intrst_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .endian_strap(endian_strap),
    .core_halted(core_halted), .prio_group(prio_group), .sys_rst_req(sys_rst_req),
    .core_rst_pulse(core_rst_pulse), .clr_active_pulse(clr_active_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Row: halted(1) wdata(32) exp_prio(3) exp_sreq(1) exp_lrst(1) exp_clra(1)
  localparam int NROW = 10;
  localparam logic [38:0] ROWS [NROW] = '{
    {1'b0, 32'h05FA_0500, 3'd5, 1'b0, 1'b0, 1'b0}, // R4 prio write
    {1'b0, 32'h1234_0300, 3'd5, 1'b0, 1'b0, 1'b0}, // R1 bad key
    {1'b1, 32'h05FA_0002, 3'd0, 1'b0, 1'b0, 1'b1}, // R7 clear-active
    {1'b1, 32'h05FA_0001, 3'd0, 1'b0, 1'b1, 1'b0}, // R6 local reset
    {1'b0, 32'h05FA_0003, 3'd0, 1'b0, 1'b0, 1'b0}, // R8 running
    {1'b0, 32'h05FA_0704, 3'd7, 1'b1, 1'b0, 1'b0}, // R5 set request
    {1'b0, 32'h05FA_0000, 3'd0, 1'b1, 1'b0, 1'b0}, // R5 zero keeps it
    {1'b1, 32'h05FA_0201, 3'd2, 1'b0, 1'b1, 1'b0}, // R6 clears request
    {1'b1, 32'h05FA_0005, 3'd0, 1'b1, 1'b0, 1'b0}, // R9 both bits
    {1'b1, 32'hFA05_0001, 3'd0, 1'b1, 1'b0, 1'b0}  // R1 read key used as write key
  };

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endian_strap = 1'b0; core_halted = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 outs", {29'd0, sys_rst_req, core_rst_pulse, clr_active_pulse}, 32'd0);
    check("R11 prio", {29'd0, prio_group}, 32'd0);
    check("R2 read image", bus_rdata, 32'hFA05_0000);

    for (int i = 0; i < NROW; i++) begin
      core_halted = ROWS[i][38];
      bus_wdata   = ROWS[i][37:6];
      bus_sel = 1'b1; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R4 prio", {29'd0, prio_group}, {29'd0, ROWS[i][5:3]});
      check("R5 sreq", {31'd0, sys_rst_req}, {31'd0, ROWS[i][2]});
      check("R6 lrst", {31'd0, core_rst_pulse}, {31'd0, ROWS[i][1]});
      check("R7 clra", {31'd0, clr_active_pulse}, {31'd0, ROWS[i][0]});
      check("R10 rdback", bus_rdata,
            {16'hFA05, 5'd0, ROWS[i][5:3], 5'd0, ROWS[i][2], 2'b00});
      bus_sel = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
      check("R6/R7 one cycle", {30'd0, core_rst_pulse, clr_active_pulse}, 32'd0);
    end

    // R3 strap visible and not writable
    endian_strap = 1'b1;
    #1;
    check("R3 strap", {31'd0, bus_rdata[15]}, 32'd1);
    bus_wdata = 32'h05FA_0000; bus_sel = 1'b1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R3 strap after write", {31'd0, bus_rdata[15]}, 32'd1);
    endian_strap = 1'b0;
    #1;
    check("R3 strap low", {31'd0, bus_rdata[15]}, 32'd0);

    // R10 all-ones keyed write while running: reserved and action bits read 0
    core_halted = 1'b0;
    bus_wdata = 32'h05FA_FFFF; bus_sel = 1'b1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R10 ones", bus_rdata, 32'hFA05_0704);
    check("R8 no pulse", {30'd0, core_rst_pulse, clr_active_pulse}, 32'd0);

    // R11 reset clears request and field
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", bus_rdata, 32'hFA05_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule